// File: doc/BRIEF.md
# HDLC Frame Transmit Sequencer

This block is the transmit control path of a bit-synchronous HDLC channel. It pulls bytes from a transmit buffer over a valid/ready handshake. It wraps each message in flags and can append a 16-bit frame check sequence. The result goes out one bit per clock on a serial line. While enabled and with no data waiting, it keeps the line busy with back-to-back flags.

Software and the surrounding channel logic steer it with single-cycle command pulses: enable, disable, transmitter reset, channel reset, abort and end-of-message. Two static configuration inputs select whether the check sequence is appended and what happens when the buffer runs dry in the middle of a frame.

Only the two reset commands act at once. Every other change of state waits until the current character or pattern has left the shifter completely, including any inserted zero. The current state is always visible on a 3-bit output so that neighbouring logic can follow the frame's progress.

Top module: `hdlc_tx_seq`

## Requirements
- R1: After `rst_n` is released the state code is 0 (disabled), `txd` is 1 and `in_ready` is 0. Buffer data is ignored in that state. An enable pulse gives state code 1 (idle) on the next clock.
- R2: In idle with no data, the line carries a continuous stream of flags 0x7E, sent least significant bit first and with no zero insertion. The first flag begins on the clock after enable.
- R3: A frame runs through state codes 2 (opening flag), 3 (characters), 4 (check sequence, only when enabled) and 5 (closing flag), in that order. Each byte goes out least significant bit first. A 0 is inserted after every five consecutive 1s inside the data and check-sequence fields.
- R4: With `cfg_crc_en`=1, the check sequence uses the polynomial x^16+x^12+x^5+1 with the register preset to all ones. Its complement is sent least significant bit first, so a receiver's running check over data plus sequence leaves residue 0xF0B8. With `cfg_crc_en`=0, state 4 never occurs and the closing flag follows the last byte.
- R5: An underrun is a character boundary with no data and no pending end-of-message. With `cfg_udr_close`=1, an underrun ends the frame normally, as end-of-message would.
- R6: With `cfg_udr_close`=0, an underrun moves the block to state code 6 (abort), which sends eight consecutive 1s.
- R7: An abort pulse takes effect at the next character or pattern boundary. After a byte starts, the state stays 3 for seven more clocks and is 6 on the eighth. An abort pulse during the abort pattern repeats the pattern. Afterwards the block goes to idle if the buffer is empty, or to the opening flag if data is waiting.
- R8: A transmitter-reset or channel-reset pulse gives state code 0 and `txd`=1 on the very next clock, from any state.
- R9: A disable pulse in idle takes effect at the end of the current flag. A disable pulse during a frame is held until the frame is closed and the block is back in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_tx_en | input | 1 | Pulse: enable transmitter |
| cmd_tx_dis | input | 1 | Pulse: disable transmitter (deferred to idle) |
| cmd_tx_rst | input | 1 | Pulse: immediate transmitter reset |
| cmd_ch_rst | input | 1 | Pulse: immediate channel reset |
| cmd_abort | input | 1 | Pulse: abort current frame |
| cmd_eom | input | 1 | Pulse: the last accepted byte ends the message |
| cfg_crc_en | input | 1 | Append check sequence |
| cfg_udr_close | input | 1 | 1: close frame on underrun; 0: abort on underrun |
| in_valid | input | 1 | Transmit buffer holds a byte |
| in_data | input | 8 | Byte from the transmit buffer |
| in_ready | output | 1 | Byte taken at this clock edge |
| txd | output | 1 | Serial transmit line |
| tx_state | output | 3 | Current state code (0..6) |

## Verification
The bench feeds ones-rich bytes such as 0xFF, 0x7E, 0x1F, 0xF8 and 0xBF, so that stuffed zeros fall on byte boundaries and across the data-to-check-sequence seam. If stuffing were dropped at a seam, the receiver-side decode in the bench would see a false flag or a corrupt residue. The bench counts the cycles between an abort pulse and the abort state. A design that acted in mid-character would leave a broken byte on the line, and one that dropped a repeated abort would leave the abort state after eight clocks instead of sixteen. Both underrun settings are driven. A swapped choice shows up as a clean frame where an abort run was expected, or the reverse. Disable is issued both in idle and at the start of a frame. A design that obeyed it at once would cut the frame short.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    ST_DIS   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_OPEN  = 3'd2,
    ST_CHAR  = 3'd3,
    ST_FCS   = 3'd4,
    ST_CLOSE = 3'd5,
    ST_ABORT = 3'd6
  } tx_state_e;

  typedef enum logic [1:0] {
    PK_FLAG  = 2'd0,
    PK_ABORT = 2'd1,
    PK_DATA  = 2'd2,
    PK_FCS   = 2'd3
  } pat_kind_e;

  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

  // Fold one byte into the running check value, low bit first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] cur, input logic [7:0] d);
    logic [15:0] c;
    logic fb;
    c = cur;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

endpackage

// File: rtl/hdlc_tx_shifter.sv
module hdlc_tx_shifter
  import hdlc_tx_pkg::*;
#(
  parameter int SH_W = 16,
  parameter int RUN  = 5,
  localparam int CNT_W = $clog2(SH_W + 1),
  localparam int ONE_W = $clog2(RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             load,
  input  logic [SH_W-1:0]  ld_word,
  input  logic [CNT_W-1:0] ld_len,
  input  logic             ld_stuff,
  output logic             bit_o,
  output logic             unit_end
);

  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ONE_W-1:0] ones_q;
  logic             stuff_en_q;

  logic             stuff_now;
  logic [ONE_W-1:0] ones_emit;

  // A zero goes out instead of payload once RUN ones were sent.
  assign stuff_now = stuff_en_q && (ones_q == ONE_W'(RUN));
  assign bit_o     = stuff_now ? 1'b0 : sh_q[0];

  always_comb begin
    if (stuff_now || !stuff_en_q) ones_emit = '0;
    else if (sh_q[0])             ones_emit = ones_q + 1'b1;
    else                          ones_emit = '0;
  end

  // Boundary: last payload bit with no stuff owed, or the owed stuff bit.
  always_comb begin
    if (stuff_now) unit_end = (cnt_q == '0);
    else           unit_end = (cnt_q == CNT_W'(1)) &&
                              !(stuff_en_q && ones_emit == ONE_W'(RUN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      ones_q     <= '0;
      stuff_en_q <= 1'b0;
    end else if (halt) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      ones_q     <= '0;
      stuff_en_q <= 1'b0;
    end else if (load) begin
      sh_q       <= ld_word;
      cnt_q      <= ld_len;
      stuff_en_q <= ld_stuff;
      ones_q     <= ld_stuff ? ones_emit : '0;
    end else if (stuff_now) begin
      ones_q <= '0;
    end else if (cnt_q != '0) begin
      sh_q   <= sh_q >> 1;
      cnt_q  <= cnt_q - 1'b1;
      ones_q <= ones_emit;
    end
  end

  p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= ONE_W'(RUN));

  p_stuff_is_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_en_q && ones_q == ONE_W'(RUN)) |-> !bit_o);

  p_end_on_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    unit_end |-> (cnt_q <= CNT_W'(1)));

endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
  import hdlc_tx_pkg::*;
#(
  parameter int FCS_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset,
  input  logic              upd,
  input  logic [DATA_W-1:0] din,
  output logic [FCS_W-1:0]  crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= FCS_W'(CRC_PRESET);
    else if (preset) crc <= FCS_W'(CRC_PRESET);
    else if (upd)    crc <= FCS_W'(crc16_byte(16'(crc), 8'(din)));
  end

  p_preset_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    preset |=> (crc == FCS_W'(CRC_PRESET)));

  p_crc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset && !upd) |=> $stable(crc));

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_tx_en,
  input  logic      cmd_tx_dis,
  input  logic      cmd_tx_rst,
  input  logic      cmd_ch_rst,
  input  logic      cmd_abort,
  input  logic      cmd_eom,
  input  logic      cfg_crc_en,
  input  logic      cfg_udr_close,
  input  logic      in_valid,
  input  logic      unit_end,
  output tx_state_e st,
  output logic      load,
  output pat_kind_e ld_kind,
  output logic      accept,
  output logic      halt
);

  tx_state_e nxt;
  logic abort_p, eom_p, dis_p;
  logic abort_req, eom_req, dis_req, rst_cmd;
  logic close_kind_fcs;

  assign rst_cmd   = cmd_tx_rst | cmd_ch_rst;
  assign abort_req = abort_p | cmd_abort;
  assign eom_req   = eom_p | cmd_eom;
  assign dis_req   = dis_p | cmd_tx_dis;
  assign close_kind_fcs = cfg_crc_en;

  always_comb begin
    nxt  = st;
    load = 1'b0;
    if (st == ST_DIS) begin
      if (abort_req) begin
        nxt = ST_ABORT; load = 1'b1;
      end else if (cmd_tx_en) begin
        nxt = ST_IDLE; load = 1'b1;
      end
    end else if (unit_end) begin
      load = 1'b1;
      if (abort_req) nxt = ST_ABORT;
      else begin
        unique case (st)
          ST_IDLE: begin
            if (in_valid)     nxt = ST_OPEN;
            else if (dis_req) begin nxt = ST_DIS; load = 1'b0; end
            else              nxt = ST_IDLE;
          end
          ST_OPEN:  nxt = in_valid ? ST_CHAR : ST_IDLE;
          ST_CHAR: begin
            if (eom_req || (!in_valid && cfg_udr_close))
              nxt = close_kind_fcs ? ST_FCS : ST_CLOSE;
            else if (in_valid) nxt = ST_CHAR;
            else               nxt = ST_ABORT;
          end
          ST_FCS:   nxt = ST_CLOSE;
          ST_CLOSE: nxt = in_valid ? ST_CHAR : ST_IDLE;
          ST_ABORT: nxt = in_valid ? ST_OPEN : ST_IDLE;
          default:  nxt = ST_IDLE;
        endcase
      end
    end
    if (rst_cmd) begin
      nxt  = ST_DIS;
      load = 1'b0;
    end
  end

  always_comb begin
    unique case (nxt)
      ST_CHAR:  ld_kind = PK_DATA;
      ST_FCS:   ld_kind = PK_FCS;
      ST_ABORT: ld_kind = PK_ABORT;
      default:  ld_kind = PK_FLAG;
    endcase
  end

  assign accept = load && (nxt == ST_CHAR);
  assign halt   = (nxt == ST_DIS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_DIS;
      abort_p <= 1'b0;
      eom_p   <= 1'b0;
      dis_p   <= 1'b0;
    end else begin
      st <= nxt;
      if (rst_cmd || (load && nxt == ST_ABORT)) abort_p <= 1'b0;
      else                                       abort_p <= abort_req;
      if (rst_cmd || (load && st == ST_CHAR && nxt != ST_CHAR) || (load && nxt == ST_ABORT))
        eom_p <= 1'b0;
      else
        eom_p <= eom_req;
      if (rst_cmd || nxt == ST_DIS || cmd_tx_en) dis_p <= 1'b0;
      else                                        dis_p <= dis_req;
    end
  end

  p_reset_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_tx_rst || cmd_ch_rst) |=> (st == ST_DIS));

  p_hold_between_units_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_DIS && !unit_end && !rst_cmd) |=> $stable(st));

  p_underrun_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHAR && unit_end && !in_valid && !eom_req && !abort_req &&
     !cfg_udr_close && !rst_cmd) |=> (st == ST_ABORT));

  p_dis_deferred_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHAR && cmd_tx_dis && !rst_cmd) |=> (st != ST_DIS));

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FCS_W     = 16,
  parameter int STUFF_RUN = 5,
  parameter int ABORT_LEN = 8,
  localparam int SH_W  = FCS_W,
  localparam int CNT_W = $clog2(SH_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_tx_en,
  input  logic              cmd_tx_dis,
  input  logic              cmd_tx_rst,
  input  logic              cmd_ch_rst,
  input  logic              cmd_abort,
  input  logic              cmd_eom,
  input  logic              cfg_crc_en,
  input  logic              cfg_udr_close,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              txd,
  output logic [2:0]        tx_state
);

  tx_state_e        st;
  pat_kind_e        ld_kind;
  logic             load, accept, halt, unit_end, bit_o;
  logic [FCS_W-1:0] crc;
  logic [SH_W-1:0]  ld_word;
  logic [CNT_W-1:0] ld_len;
  logic             ld_stuff;
  logic             crc_preset;

  hdlc_tx_ctrl u_ctrl (
    .clk, .rst_n,
    .cmd_tx_en, .cmd_tx_dis, .cmd_tx_rst, .cmd_ch_rst, .cmd_abort, .cmd_eom,
    .cfg_crc_en, .cfg_udr_close, .in_valid, .unit_end,
    .st, .load, .ld_kind, .accept, .halt
  );

  always_comb begin
    unique case (ld_kind)
      PK_DATA: begin
        ld_word = SH_W'(in_data); ld_len = CNT_W'(DATA_W); ld_stuff = 1'b1;
      end
      PK_FCS: begin
        ld_word = SH_W'(~crc);    ld_len = CNT_W'(FCS_W);  ld_stuff = 1'b1;
      end
      PK_ABORT: begin
        ld_word = '1;             ld_len = CNT_W'(ABORT_LEN); ld_stuff = 1'b0;
      end
      default: begin
        ld_word = SH_W'(FLAG_BYTE); ld_len = CNT_W'(8);    ld_stuff = 1'b0;
      end
    endcase
  end

  hdlc_tx_shifter #(.SH_W(SH_W), .RUN(STUFF_RUN)) u_shift (
    .clk, .rst_n, .halt, .load, .ld_word, .ld_len, .ld_stuff,
    .bit_o, .unit_end
  );

  assign crc_preset = load && (ld_kind == PK_FLAG || ld_kind == PK_ABORT);

  hdlc_tx_fcs #(.FCS_W(FCS_W), .DATA_W(DATA_W)) u_fcs (
    .clk, .rst_n, .preset(crc_preset), .upd(accept), .din(in_data), .crc
  );

  assign in_ready = accept;
  assign txd      = (st == ST_DIS) ? 1'b1 : bit_o;
  assign tx_state = st;

  p_no_accept_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DIS) |-> !in_ready);

  p_ready_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> unit_end);

endmodule

// File: tb/hdlc_tx_seq_bench.sv
module hdlc_tx_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BUF_N = 4096;

  logic clk = 0, rst_n = 0;
  logic cmd_tx_en = 0, cmd_tx_dis = 0, cmd_tx_rst = 0, cmd_ch_rst = 0;
  logic cmd_abort = 0, cmd_eom = 0, cfg_crc_en = 0, cfg_udr_close = 0;
  logic in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready, txd;
  logic [2:0] tx_state;

  hdlc_tx_seq u_hdlc_tx_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit rec = 0;
  bit rb [BUF_N];
  int rc = 0;
  bit seen [8];
  logic [7:0] frb [32];
  int frn;
  logic [7:0] txq [8];

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rec) begin
      if (rc < BUF_N) rb[rc] = txd;
      rc++;
      seen[tx_state] = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic clear_rec();
    rc = 0;
    for (int i = 0; i < 8; i++) seen[i] = 0;
    rec = 1;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  function automatic bit is_flag(int i);
    for (int k = 0; k < 8; k++)
      if (rb[i+k] != ((8'h7E >> k) & 1)) return 0;
    return 1;
  endfunction

  function automatic int max_run();
    int r = 0, m = 0;
    for (int i = 0; i < rc && i < BUF_N; i++) begin
      r = rb[i] ? r + 1 : 0;
      if (r > m) m = r;
    end
    return m;
  endfunction

  // Receiver-side decode: first non-empty gap between two flags, destuffed.
  task automatic decode(output bit ok);
    int f1 = -1, f2 = -1, i = 0, ones = 0, nb = 0, lim;
    ok = 0; frn = 0;
    lim = (rc < BUF_N) ? rc : BUF_N;
    while (i + 8 <= lim && f2 < 0) begin
      if (is_flag(i)) begin
        if (f1 >= 0 && i > f1 + 8) f2 = i;
        else begin f1 = i; i += 8; end
      end else i++;
    end
    if (f2 < 0) return;
    for (int k = f1 + 8; k < f2; k++) begin
      if (ones == 5) begin ones = 0; continue; end
      if (nb / 8 < 32) frb[nb/8][nb%8] = rb[k];
      nb++;
      ones = rb[k] ? ones + 1 : 0;
    end
    frn = nb / 8;
    ok = (nb % 8 == 0) && frn <= 32;
  endtask

  function automatic logic [15:0] residue(int n);
    logic [15:0] c = 16'hFFFF;
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++)
        c = (c[0] ^ frb[b][k]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  task automatic push(int n, bit eom);
    bit r;
    int i = 0;
    @(negedge clk);
    in_valid = 1; in_data = txq[0];
    while (i < n) begin
      #1; r = in_ready;
      @(negedge clk);
      if (r) begin
        i++;
        if (i < n) in_data = txq[i];
        else begin in_valid = 0; cmd_eom = eom; end
      end
    end
    @(negedge clk); cmd_eom = 0;
  endtask

  task automatic wait_quiet(int want);
    int q = 0, t = 0;
    while (q < 24 && t < 2000) begin
      @(negedge clk); #2;
      q = (tx_state == want[2:0]) ? q + 1 : 0;
      t++;
    end
  endtask

  function automatic logic [7:0] pat(int k);
    case (k % 6)
      0: return 8'hFF; 1: return 8'h7E; 2: return 8'h1F;
      3: return 8'hF8; 4: return 8'h00; default: return 8'hBF;
    endcase
  endfunction

  initial begin
    bit ok;
    int cnt;
    repeat (3) @(negedge clk);
    #1;
    check(tx_state == 0 && txd == 1 && in_ready == 0, "R1 reset state", tx_state, 0);
    rst_n = 1;
    @(negedge clk); in_valid = 1; in_data = 8'h55;
    repeat (6) @(negedge clk);
    #1;
    check(tx_state == 0 && in_ready == 0 && txd == 1, "R1 data ignored while disabled", tx_state, 0);
    @(negedge clk); in_valid = 0;

    // Enable, then idle flags
    pulse(cmd_tx_en);
    clear_rec();
    #1;
    check(tx_state == 1, "R1 enable to idle", tx_state, 1);
    repeat (48) @(negedge clk);
    ok = 1;
    for (int k = 0; k < 40; k++) if (rb[k] != ((8'h7E >> (k % 8)) & 1)) ok = 0;
    check(ok, "R2 continuous flags from first bit", ok, 1);

    // Frame sweep over check-sequence setting and length
    cfg_udr_close = 0;
    for (int c = 0; c < 2; c++) begin
      cfg_crc_en = c[0];
      for (int n = 1; n <= 5; n++) begin
        for (int i = 0; i < n; i++) txq[i] = pat(i + n + c);
        wait_quiet(1);
        clear_rec();
        push(n, 1);
        wait_quiet(1);
        decode(ok);
        check(ok && frn == n + 2*c, "R3 frame length", frn, n + 2*c);
        ok = 1;
        for (int i = 0; i < n; i++) if (frb[i] != txq[i]) ok = 0;
        check(ok, "R3 frame bytes", ok, 1);
        check(seen[2] && seen[3] && seen[5] && !seen[6], "R3 state path", seen[6], 0);
        if (c == 1) check(residue(frn) == 16'hF0B8, "R4 check residue", residue(frn), 16'hF0B8);
        check(seen[4] == c[0], "R4 check state only when enabled", seen[4], c);
      end
    end

    // Underrun closes frame
    cfg_crc_en = 1; cfg_udr_close = 1;
    for (int i = 0; i < 3; i++) txq[i] = pat(i);
    clear_rec();
    push(3, 0);
    wait_quiet(1);
    decode(ok);
    check(ok && frn == 5, "R5 underrun closes frame", frn, 5);
    check(residue(frn) == 16'hF0B8 && !seen[6], "R5 underrun frame intact", residue(frn), 16'hF0B8);

    // Underrun aborts
    cfg_udr_close = 0;
    clear_rec();
    push(2, 0);
    wait_quiet(1);
    check(seen[6] == 1, "R6 underrun enters abort", seen[6], 1);
    check(max_run() >= 7, "R6 abort run of ones", max_run(), 7);

    // Abort timing on a byte boundary, data still waiting afterwards
    @(negedge clk); in_valid = 1; in_data = 8'h00;
    ok = 0;
    while (!ok) begin
      #1; ok = in_ready && tx_state == 3;
      @(negedge clk);
    end
    cmd_abort = 1;
    @(negedge clk); cmd_abort = 0;
    cnt = 0;
    for (int k = 1; k <= 7; k++) begin
      #1; if (tx_state == 3) cnt++;
      @(negedge clk);
    end
    #1;
    check(cnt == 7, "R7 abort waits for byte end", cnt, 7);
    check(tx_state == 6, "R7 abort at boundary", tx_state, 6);
    repeat (8) @(negedge clk);
    #1;
    check(tx_state == 2, "R7 abort then opening flag with data", tx_state, 2);
    in_valid = 0;
    wait_quiet(1);

    // Repeated abort
    pulse(cmd_abort);
    while (tx_state != 6) @(negedge clk);
    cmd_abort = 1;
    @(negedge clk); cmd_abort = 0;
    cnt = 1;
    #1;
    while (tx_state == 6 && cnt < 40) begin
      cnt++;
      @(negedge clk); #1;
    end
    check(cnt == 16, "R7 repeated abort doubles pattern", cnt, 16);
    check(tx_state == 1, "R7 abort then idle when empty", tx_state, 1);

    // Immediate resets
    @(negedge clk); in_valid = 1; in_data = 8'hA5;
    while (tx_state != 3) @(negedge clk);
    pulse(cmd_tx_rst);
    #1;
    check(tx_state == 0 && txd == 1, "R8 transmitter reset immediate", tx_state, 0);
    in_valid = 0;
    pulse(cmd_tx_en);
    @(negedge clk); in_valid = 1;
    while (tx_state != 3) @(negedge clk);
    pulse(cmd_ch_rst);
    #1;
    check(tx_state == 0 && txd == 1, "R8 channel reset immediate", tx_state, 0);
    in_valid = 0;

    // Disable in idle
    pulse(cmd_tx_en);
    repeat (20) @(negedge clk);
    pulse(cmd_tx_dis);
    cnt = 0;
    while (tx_state != 0 && cnt < 20) begin @(negedge clk); cnt++; end
    #1;
    check(tx_state == 0 && cnt <= 8 && txd == 1, "R9 disable at flag end", cnt, 8);

    // Disable during frame
    pulse(cmd_tx_en);
    wait_quiet(1);
    for (int i = 0; i < 3; i++) txq[i] = pat(i + 3);
    clear_rec();
    fork
      push(3, 1);
      pulse(cmd_tx_dis);
    join
    cnt = 0;
    while (tx_state != 0 && cnt < 400) begin @(negedge clk); cnt++; end
    rec = 0;
    decode(ok);
    check(ok && frn == 5 && residue(frn) == 16'hF0B8, "R9 frame completes before disable", frn, 5);
    check(tx_state == 0 && seen[5], "R9 disabled after frame", tx_state, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule